// File: doc/BRIEF.md
# Protected-Write Clock Prescaler

This block divides a master clock by a power of two and presents the result as a one-cycle clock-enable pulse. The CPU and every synchronous peripheral that should run at the reduced rate share this pulse. An 8-bit control register sits on a simple register bus with a write strobe, write data and read data. The register holds the division code. A change-enable flag guards that code.

Software changes the factor in two steps. First it writes a byte with only the top bit set, which opens a short window. Then, inside that window, it writes the new code with the top bit clear. Any other write leaves the factor alone. The window closes by itself after a fixed number of cycles, and sending the opening byte again does not prolong it. A newly accepted code does not take effect at once. The divider picks it up only when its current period ends, so no enable period is cut short and none is stretched beyond the old or the new length.

Top module: `clk_prescale_ctrl`

## Requirements
- R1: Read data is laid out as follows: bit 7 is the live change-enable flag, bits 6 to 4 always read zero, and bits 3 to 0 hold the accepted division code. Writes to bits 6 to 4 are never stored.
- R2: The change-enable flag is set only by a write of exactly 0x80, meaning bit 7 is one and all other bits are zero.
- R3: Once set, the change-enable flag reads one for exactly 4 cycles and then clears by itself. Writing 0x80 again while it is set neither lengthens nor shortens that time.
- R4: A write with bit 7 at zero, made while the flag is set (the 4th cycle after the unlock write being the last such chance), loads bits 3 to 0 as the new code and clears the flag at the same clock edge.
- R5: A write with bit 7 at zero made while the flag is clear is discarded, and the code keeps its old value.
- R6: A code of 9 to 15 written inside the window is not stored, and the previous code is kept. The write still closes the window.
- R7: After reset the register reads 0x00 and the enable output is high on every cycle (divide by 1).
- R8: With an active code c from 0 to 8, the enable output is high for one cycle out of every 2^c cycles.
- R9: A newly accepted code takes effect only once the current enable period has completed. The first pulse after the change still follows the old period, and later pulses follow the new one.
- R10: A write with bit 7 at one and any other bit non-zero changes neither the flag nor the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data: flag, zero bits, accepted code |
| div_clk_en | output | 1 | Divided clock-enable pulse |

## Verification
The bench builds the block with its default parameters: a 4-cycle window, a 4-bit code field, codes up to 8 and a combinational enable output. With these values the window's last accepting cycle and its first rejecting cycle are each a few writes away. The slowest factor, 256, can be measured directly, and the old-period and new-period pulses around a factor change in both directions can be timed exactly.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;

   localparam int CTRL_W   = 8;
   localparam int GUARD_B  = 7;

   typedef enum logic [1:0] {
      WR_NONE   = 2'd0,
      WR_UNLOCK = 2'd1,
      WR_SELECT = 2'd2,
      WR_DROP   = 2'd3
   } wr_kind_e;

endpackage

// File: rtl/clkpre_wr_decode.sv
module clkpre_wr_decode
   import clkpre_pkg::*;
(
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              guard_open,
   output wr_kind_e          kind
);

   localparam logic [CTRL_W-1:0] UNLOCK_WORD = CTRL_W'(1) << GUARD_B;

   always_comb begin
      kind = WR_NONE;
      if (wr_en) begin
         if (wr_data[GUARD_B]) begin
            // opening word only counts while the window is shut
            if (wr_data == UNLOCK_WORD && !guard_open) kind = WR_UNLOCK;
            else                                        kind = WR_DROP;
         end else begin
            if (guard_open) kind = WR_SELECT;
            else            kind = WR_DROP;
         end
      end
   end

endmodule

// File: rtl/clkpre_guard.sv
module clkpre_guard
   import clkpre_pkg::*;
#(
   parameter int UNLOCK_CYCLES = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  wr_kind_e kind,
   output logic     guard_open
);

   localparam int TMR_W = $clog2(UNLOCK_CYCLES + 1);
   localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(UNLOCK_CYCLES - 1);

   logic [TMR_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         guard_open <= 1'b0;
         remain     <= '0;
      end else if (!guard_open) begin
         if (kind == WR_UNLOCK) begin
            guard_open <= 1'b1;
            remain     <= TMR_LOAD;
         end
      end else if (kind == WR_SELECT) begin
         guard_open <= 1'b0;
         remain     <= '0;
      end else if (remain == '0) begin
         guard_open <= 1'b0;
      end else begin
         remain <= remain - 1'b1;
      end
   end

endmodule

// File: rtl/clkpre_sel.sv
module clkpre_sel
   import clkpre_pkg::*;
#(
   parameter int SEL_W      = 4,
   parameter int MAX_CODE   = 8,
   parameter int RESET_CODE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wr_kind_e         kind,
   input  logic [SEL_W-1:0] wr_code,
   output logic [SEL_W-1:0] sel_code
);

   logic code_ok;

   assign code_ok = (int'(wr_code) <= MAX_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n)                             sel_code <= SEL_W'(RESET_CODE);
      else if (kind == WR_SELECT && code_ok)  sel_code <= wr_code;
   end

endmodule

// File: rtl/clkpre_divider.sv
module clkpre_divider #(
   parameter int SEL_W      = 4,
   parameter int MAX_CODE   = 8,
   parameter int RESET_CODE = 0,
   parameter bit REG_OUT    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_code,
   output logic             div_clk_en
);

   localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

   logic [SEL_W-1:0] active;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] limit;
   logic             wrap;

   always_comb begin
      for (int i = 0; i < CNT_W; i++) begin
         limit[i] = (i < int'(active));
      end
   end

   assign wrap = (count == limit);

   // factor only swaps at a period boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= SEL_W'(RESET_CODE);
         count  <= '0;
      end else if (wrap) begin
         active <= sel_code;
         count  <= '0;
      end else begin
         count  <= count + 1'b1;
      end
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic en_q;
         always_ff @(posedge clk) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= wrap;
         end
         assign div_clk_en = en_q;
      end else begin : g_comb_out
         assign div_clk_en = wrap;
      end
   endgenerate

endmodule

// File: rtl/clk_prescale_ctrl.sv
module clk_prescale_ctrl
   import clkpre_pkg::*;
#(
   parameter int UNLOCK_CYCLES = 4,
   parameter int SEL_W         = 4,
   parameter int MAX_CODE      = 8,
   parameter int RESET_CODE    = 0,
   parameter bit REG_OUT       = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] rd_data,
   output logic              div_clk_en
);

   localparam int PAD_W = GUARD_B - SEL_W;

   generate
      if (SEL_W < 1 || SEL_W > GUARD_B) begin : g_bad_sel_w
         $error("SEL_W must lie between 1 and the guard bit position");
      end
      if (MAX_CODE < 0 || MAX_CODE >= (1 << SEL_W)) begin : g_bad_max
         $error("MAX_CODE must fit in the select field");
      end
      if (RESET_CODE < 0 || RESET_CODE > MAX_CODE) begin : g_bad_rst
         $error("RESET_CODE must be a legal code");
      end
      if (UNLOCK_CYCLES < 1) begin : g_bad_win
         $error("UNLOCK_CYCLES must be at least one");
      end
   endgenerate

   wr_kind_e         kind;
   logic             guard_open;
   logic [SEL_W-1:0] sel_code;

   clkpre_wr_decode u_dec (
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .guard_open (guard_open),
      .kind       (kind)
   );

   clkpre_guard #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .guard_open (guard_open)
   );

   clkpre_sel #(
      .SEL_W      (SEL_W),
      .MAX_CODE   (MAX_CODE),
      .RESET_CODE (RESET_CODE)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .wr_code  (wr_data[SEL_W-1:0]),
      .sel_code (sel_code)
   );

   clkpre_divider #(
      .SEL_W      (SEL_W),
      .MAX_CODE   (MAX_CODE),
      .RESET_CODE (RESET_CODE),
      .REG_OUT    (REG_OUT)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_code   (sel_code),
      .div_clk_en (div_clk_en)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {guard_open, {PAD_W{1'b0}}, sel_code};
      end else begin : g_nopad
         assign rd_data = {guard_open, sel_code};
      end
   endgenerate

endmodule

// File: rtl/clk_prescale_ctrl_chk.sv
module clk_prescale_ctrl_chk #(
   parameter int UNLOCK_CYCLES = 4,
   parameter int SEL_W         = 4,
   parameter int MAX_CODE      = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       div_clk_en
);

   localparam logic [7:0] CODE_MASK = 8'((1 << SEL_W) - 1);
   localparam logic [7:0] RSVD_MASK = 8'h7F & ~CODE_MASK;

   logic [15:0]       open_cnt;
   logic [MAX_CODE:0] gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_cnt <= '0;
         gap      <= '0;
      end else begin
         open_cnt <= rd_data[7] ? open_cnt + 1'b1 : '0;
         gap      <= div_clk_en ? '0 : gap + 1'b1;
      end
   end

   assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & RSVD_MASK) == 8'h00);

   assert_unlock_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[7]) |-> $past(wr_en && wr_data == 8'h80));

   assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7] |-> open_cnt < 16'(UNLOCK_CYCLES));

   assert_select_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[7] && rd_data[7]) |=> !rd_data[7]);

   assert_code_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data & CODE_MASK) |-> $past(wr_en && !wr_data[7] && rd_data[7]));

   assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_data & CODE_MASK) <= MAX_CODE);

   assert_period_pow2_R8: assert property (@(posedge clk) disable iff (!rst_n)
      div_clk_en |-> $countones({1'b0, gap} + 1'b1) == 1);

endmodule

bind clk_prescale_ctrl clk_prescale_ctrl_chk #(
   .UNLOCK_CYCLES (UNLOCK_CYCLES),
   .SEL_W         (SEL_W),
   .MAX_CODE      (MAX_CODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .div_clk_en (div_clk_en)
);

// File: tb/tb_clk_prescale_ctrl.sv
`timescale 1ns/1ps
module tb_clk_prescale_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       div_clk_en;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   clk_prescale_ctrl dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .div_clk_en (div_clk_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; one write consumes one rising edge
   task automatic wr(input logic [7:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 8'h00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_code(input logic [7:0] c);
      wr(8'h80);
      wr(c);
   endtask

   task automatic next_gap(output int n);
      int guard = 0;
      while (!div_clk_en && guard < 1000) begin @(negedge clk); guard++; end
      n = 0;
      do begin @(negedge clk); n++; end while (!div_clk_en && n < 1000);
   endtask

   task automatic t_reset_R7;
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check(rd_data == 8'h00, "R7 reset read", rd_data, 8'h00);
      for (int i = 0; i < 3; i++) begin
         check(div_clk_en == 1'b1, "R7 enable every cycle", div_clk_en, 1);
         idle(1);
      end
   endtask

   task automatic t_layout_R1;
      set_code(8'h75);
      check(rd_data == 8'h05, "R1 reserved bits zero, code stored", rd_data, 8'h05);
   endtask

   task automatic t_unlock_R2;
      wr(8'h80);
      check(rd_data == 8'h85, "R2 unlock word sets flag", rd_data, 8'h85);
      idle(5);
   endtask

   task automatic t_window_R3;
      wr(8'h80);
      check(rd_data[7] == 1'b1, "R3 flag after unlock", rd_data[7], 1);
      for (int i = 0; i < 3; i++) begin
         idle(1);
         check(rd_data[7] == 1'b1, "R3 flag held", rd_data[7], 1);
      end
      idle(1);
      check(rd_data[7] == 1'b0, "R3 flag timed out", rd_data[7], 0);
   endtask

   task automatic t_rewrite_R3;
      wr(8'h80);
      wr(8'h80);
      check(rd_data[7] == 1'b1, "R3 rewrite does not clear", rd_data[7], 1);
      idle(1);
      check(rd_data[7] == 1'b1, "R3 rewrite window", rd_data[7], 1);
      idle(1);
      check(rd_data[7] == 1'b1, "R3 rewrite window", rd_data[7], 1);
      idle(1);
      check(rd_data[7] == 1'b0, "R3 rewrite does not extend", rd_data[7], 0);
   endtask

   task automatic t_select_R4;
      set_code(8'h02);
      check(rd_data == 8'h02, "R4 code loaded and flag cleared", rd_data, 8'h02);
      wr(8'h80);
      idle(3);
      wr(8'h04);
      check(rd_data == 8'h04, "R4 last cycle of window accepts", rd_data, 8'h04);
   endtask

   task automatic t_closed_R5;
      wr(8'h80);
      idle(4);
      wr(8'h06);
      check(rd_data == 8'h04, "R5 write after window dropped", rd_data, 8'h04);
      wr(8'h01);
      check(rd_data == 8'h04, "R5 write without unlock dropped", rd_data, 8'h04);
   endtask

   task automatic t_bad_code_R6;
      set_code(8'h0C);
      check(rd_data == 8'h04, "R6 code 12 ignored, window closed", rd_data, 8'h04);
      set_code(8'h09);
      check(rd_data == 8'h04, "R6 code 9 ignored", rd_data, 8'h04);
   endtask

   task automatic t_bad_unlock_R10;
      wr(8'h81);
      check(rd_data == 8'h04, "R10 0x81 no unlock", rd_data, 8'h04);
      wr(8'h01);
      check(rd_data == 8'h04, "R10 follow-up select dropped", rd_data, 8'h04);
      wr(8'hFF);
      check(rd_data == 8'h04, "R10 0xFF no effect", rd_data, 8'h04);
   endtask

   task automatic t_period_R8(input int c);
      int g;
      set_code(8'(c));
      next_gap(g);
      next_gap(g);
      check(g == (1 << c), $sformatf("R8 period for code %0d", c), g, 1 << c);
   endtask

   task automatic t_boundary_R9;
      int n;
      int g;
      set_code(8'h03);
      next_gap(g);
      next_gap(g);
      while (!div_clk_en) @(negedge clk);
      wr(8'h80);
      wr(8'h01);
      n = 2;
      while (!div_clk_en && n < 1000) begin @(negedge clk); n++; end
      check(n == 8, "R9 old period kept after 8->2", n, 8);
      next_gap(g);
      check(g == 2, "R9 new period after 8->2", g, 2);
      wr(8'h80);
      wr(8'h03);
      n = 2;
      while (!div_clk_en && n < 1000) begin @(negedge clk); n++; end
      check(n == 2, "R9 old period kept after 2->8", n, 2);
      next_gap(g);
      check(g == 8, "R9 new period after 2->8", g, 8);
   endtask

   initial begin
      t_reset_R7();
      t_layout_R1();
      t_unlock_R2();
      t_window_R3();
      t_rewrite_R3();
      t_select_R4();
      t_closed_R5();
      t_bad_code_R6();
      t_bad_unlock_R10();
      t_period_R8(0);
      t_period_R8(1);
      t_period_R8(3);
      t_period_R8(8);
      t_boundary_R9();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule